// File: doc/BRIEF.md
# Hamming SEC-DED Codec for an 8-bit Word

This block protects one byte with a positional single-error-correcting, double-error-detecting code. The encoder half takes an 8-bit data word and returns a 13-bit codeword. The codeword holds four even-parity check bits at the power-of-two positions and one overall parity bit at the end. The checker half takes a 13-bit codeword that may have been corrupted on its way through storage or a link. It returns the 4-bit syndrome, the recovered data byte, a single-error flag with the failing position, and a double-error flag.

Both halves are purely combinational and independent, so one instance can sit on the write side and the read side of a protected store at once. Codeword positions are counted from 1. Vector bit `p-1` carries position `p`, which means a nonzero syndrome can be read directly as a bit position.

Top module: `ham_secded_codec`

## Requirements
- R1: Data bit i (bit 0 first) occupies the i-th non-power-of-two position in ascending order, i.e. positions 3, 5, 6, 7, 9, 10, 11, 12; codeword vector bit p-1 holds position p.
- R2: The check bit at position 2^k (k = 0..3) is chosen so that the XOR over all positions 1..12 whose index has bit k set is zero.
- R3: Position 13 is chosen so that the XOR of all 13 codeword bits is zero.
- R4: The syndrome is {C8, C4, C2, C1} with C8 as bit 3, where Ck is the XOR over positions 1..12 whose index has weight k set; an undisturbed codeword gives syndrome 0 and both flags low.
- R5: With exactly one flipped bit at position 1..12, the syndrome equals that position, the single flag is high, the reported position equals it, and the data output equals the original byte.
- R6: A zero syndrome with odd overall parity raises the single flag, reports position 13, and returns the data unchanged.
- R7: A nonzero syndrome with even overall parity raises the double flag, reports position 0, and returns the data extracted from the received word without any correction.
- R8: A syndrome of 13, 14 or 15 with odd overall parity is reported as a double error, not a single error, and no bit is corrected.
- R9: The two flags are never high together; with neither flag high the reported position is 0.
- R10: Data byte 8'hC4 encodes to codeword 13'h0C21.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data_i | input | 8 | Data byte to be encoded |
| enc_code_o | output | 13 | Codeword; bit p-1 is position p |
| chk_code_i | input | 13 | Received codeword to check |
| chk_syndrome_o | output | 4 | Syndrome {C8, C4, C2, C1} |
| chk_data_o | output | 8 | Recovered data byte |
| chk_single_o | output | 1 | A single correctable error was found |
| chk_err_pos_o | output | 4 | Position of the corrected bit, 1..13, else 0 |
| chk_double_o | output | 1 | An uncorrectable error was found |

## Verification
The checker is fed the bench's own encoding of each byte with zero, one or two flipped positions. Clean words confirm that the syndrome and the flags stay silent. Single flips at each of the 13 positions separate in-range correction from the overall-parity-only case. Pairs of flips show that a nonzero syndrome with even parity is never mistaken for a correctable error. Directed three-bit flips drive the syndrome to 13, 14 and 15 to show that out-of-range pointers are refused. Walking-one bytes and the 8'hC4 case pin down the data placement and the check-bit groups, independently of the checker.

// File: rtl/hamming_pkg.sv
package hamming_pkg;

    // Geometry of the code
    localparam int DATA_W = 8;
    localparam int PAR_W  = 4;
    localparam int HAM_W  = DATA_W + PAR_W;     // positions covered by syndrome
    localparam int CODE_W = HAM_W + 1;          // plus overall parity
    localparam int POS_W  = $clog2(CODE_W + 1); // holds 0..CODE_W

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [HAM_W-1:0]  ham_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [PAR_W-1:0]  syn_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_SINGLE  = 2'd1,   // correctable, inside 1..HAM_W
        ERR_OVERALL = 2'd2,   // only the overall parity bit is wrong
        ERR_DOUBLE  = 2'd3    // uncorrectable
    } err_kind_e;

    typedef struct packed {
        syn_t syndrome;
        logic parity_fail;
    } chk_info_t;

    typedef struct packed {
        err_kind_e kind;
        pos_t      pos;
    } verdict_t;

    function automatic logic is_pow2(int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Position (1-based) of data bit idx
    function automatic int data_pos(int idx);
        int seen;
        int found;
        seen  = 0;
        found = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if (!is_pow2(p)) begin
                if (seen == idx) found = p;
                seen++;
            end
        end
        return found;
    endfunction

    // Positions whose index has weight 2^k set
    function automatic ham_t group_mask(int k);
        ham_t m;
        m = '0;
        for (int p = 1; p <= HAM_W; p++) begin
            m[p-1] = ((p >> k) & 1) == 1;
        end
        return m;
    endfunction

    // Data bits scattered into their positions, check positions zero
    function automatic ham_t place(data_t d);
        ham_t w;
        w = '0;
        for (int i = 0; i < DATA_W; i++) begin
            w[data_pos(i)-1] = d[i];
        end
        return w;
    endfunction

    function automatic data_t extract(ham_t w);
        data_t d;
        for (int i = 0; i < DATA_W; i++) begin
            d[i] = w[data_pos(i)-1];
        end
        return d;
    endfunction

endpackage

// File: rtl/ham_encoder.sv
module ham_encoder
    import hamming_pkg::*;
(
    input  data_t data_i,
    output code_t code_o
);
    ham_t placed;
    ham_t body;

    assign placed = place(data_i);

    generate
        for (genvar k = 0; k < PAR_W; k++) begin : g_check
            // placed is zero at every check position, so the group mask
            // can include the check bit itself
            assign body[(1 << k) - 1] = ^(placed & group_mask(k));
        end
        for (genvar i = 0; i < DATA_W; i++) begin : g_data
            assign body[data_pos(i) - 1] = data_i[i];
        end
    endgenerate

    assign code_o = {^body, body};

endmodule

// File: rtl/ham_syndrome.sv
module ham_syndrome
    import hamming_pkg::*;
(
    input  code_t     code_i,
    output chk_info_t info_o
);
    syn_t syn;

    generate
        for (genvar k = 0; k < PAR_W; k++) begin : g_syn
            assign syn[k] = ^(code_i[HAM_W-1:0] & group_mask(k));
        end
    endgenerate

    assign info_o = {syn, ^code_i};

endmodule

// File: rtl/ham_classify.sv
module ham_classify
    import hamming_pkg::*;
(
    input  chk_info_t info_i,
    output verdict_t  verdict_o
);
    localparam pos_t LAST_POS = pos_t'(HAM_W);
    localparam pos_t OVR_POS  = pos_t'(CODE_W);

    pos_t pointer;
    assign pointer = pos_t'(info_i.syndrome);

    always_comb begin
        verdict_o.kind = ERR_NONE;
        verdict_o.pos  = '0;
        if (info_i.syndrome == '0) begin
            if (info_i.parity_fail) begin
                verdict_o.kind = ERR_OVERALL;
                verdict_o.pos  = OVR_POS;
            end
        end else if (!info_i.parity_fail) begin
            verdict_o.kind = ERR_DOUBLE;
        end else if (pointer > LAST_POS) begin
            verdict_o.kind = ERR_DOUBLE;
        end else begin
            verdict_o.kind = ERR_SINGLE;
            verdict_o.pos  = pointer;
        end
    end

endmodule

// File: rtl/ham_correct.sv
module ham_correct
    import hamming_pkg::*;
(
    input  ham_t     word_i,
    input  verdict_t verdict_i,
    output data_t    data_o
);
    ham_t flip;

    generate
        for (genvar p = 0; p < HAM_W; p++) begin : g_flip
            assign flip[p] = (verdict_i.kind == ERR_SINGLE) &&
                             (verdict_i.pos == pos_t'(p + 1));
        end
    endgenerate

    assign data_o = extract(word_i ^ flip);

endmodule

// File: rtl/ham_secded_codec.sv
module ham_secded_codec
    import hamming_pkg::*;
(
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic [CODE_W-1:0] chk_code_i,
    output logic [PAR_W-1:0]  chk_syndrome_o,
    output logic [DATA_W-1:0] chk_data_o,
    output logic              chk_single_o,
    output logic [POS_W-1:0]  chk_err_pos_o,
    output logic              chk_double_o
);
    chk_info_t info;
    verdict_t  verdict;

    ham_encoder u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_o)
    );

    ham_syndrome u_syn (
        .code_i (chk_code_i),
        .info_o (info)
    );

    ham_classify u_cls (
        .info_i    (info),
        .verdict_o (verdict)
    );

    ham_correct u_cor (
        .word_i    (chk_code_i[HAM_W-1:0]),
        .verdict_i (verdict),
        .data_o    (chk_data_o)
    );

    assign chk_syndrome_o = info.syndrome;
    assign chk_single_o   = (verdict.kind == ERR_SINGLE) || (verdict.kind == ERR_OVERALL);
    assign chk_double_o   = (verdict.kind == ERR_DOUBLE);
    assign chk_err_pos_o  = verdict.pos;

endmodule

// File: rtl/ham_secded_codec_chk.sv
module ham_secded_codec_chk
    import hamming_pkg::*;
(
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CODE_W-1:0] enc_code_o,
    input logic [CODE_W-1:0] chk_code_i,
    input logic [PAR_W-1:0]  chk_syndrome_o,
    input logic [DATA_W-1:0] chk_data_o,
    input logic              chk_single_o,
    input logic [POS_W-1:0]  chk_err_pos_o,
    input logic              chk_double_o
);
    logic odd_in;
    assign odd_in = ^chk_code_i;

    always_comb begin
        assert_enc_even_R3: assert (^enc_code_o == 1'b0)
            else $error("encoder output has odd overall parity");

        assert_flags_exclusive_R9: assert (!(chk_single_o && chk_double_o))
            else $error("single and double flags both high");

        assert_quiet_clean_R4: assert (!((chk_syndrome_o == '0) && !odd_in) ||
                                       (!chk_single_o && !chk_double_o && chk_err_pos_o == '0))
            else $error("clean word raised a flag");

        assert_single_points_R5: assert (!(chk_single_o && chk_err_pos_o != '0 &&
                                           chk_err_pos_o <= pos_t'(HAM_W)) ||
                                         (pos_t'(chk_syndrome_o) == chk_err_pos_o))
            else $error("single position differs from syndrome");

        assert_overall_only_R6: assert (!(chk_single_o && chk_err_pos_o == pos_t'(CODE_W)) ||
                                        (chk_syndrome_o == '0 && odd_in))
            else $error("position 13 reported without zero syndrome");

        assert_double_quiet_pos_R7: assert (!chk_double_o || chk_err_pos_o == '0)
            else $error("double error reported a position");

        assert_range_refused_R8: assert (!(pos_t'(chk_syndrome_o) > pos_t'(HAM_W)) ||
                                         (!chk_single_o && chk_double_o))
            else $error("syndrome beyond last position not refused");
    end

    logic unused_ok;
    assign unused_ok = ^{enc_data_i, chk_data_o};

endmodule

bind ham_secded_codec ham_secded_codec_chk u_chk (.*);

// File: tb/sim_ham_secded_codec.sv
`timescale 1ns/1ps
module sim_ham_secded_codec;

    localparam int DPOS [8] = '{3, 5, 6, 7, 9, 10, 11, 12};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  enc_data_i = '0;
    logic [12:0] enc_code_o;
    logic [12:0] chk_code_i = '0;
    logic [3:0]  chk_syndrome_o;
    logic [7:0]  chk_data_o;
    logic        chk_single_o;
    logic [3:0]  chk_err_pos_o;
    logic        chk_double_o;

    always #2 clk = ~clk;   // 250 MHz

    ham_secded_codec u0 (
        .enc_data_i     (enc_data_i),
        .enc_code_o     (enc_code_o),
        .chk_code_i     (chk_code_i),
        .chk_syndrome_o (chk_syndrome_o),
        .chk_data_o     (chk_data_o),
        .chk_single_o   (chk_single_o),
        .chk_err_pos_o  (chk_err_pos_o),
        .chk_double_o   (chk_double_o)
    );

    typedef struct {
        string       tag;
        logic [12:0] code;
        logic [3:0]  syn;
        logic [7:0]  data;
        logic        single;
        logic [3:0]  pos;
        logic        dbl;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    function automatic logic [12:0] ref_encode(logic [7:0] d);
        logic [12:0] c;
        c = '0;
        for (int i = 0; i < 8; i++) c[DPOS[i]-1] = d[i];
        for (int q = 1; q <= 8; q = q * 2) begin
            logic v;
            v = 1'b0;
            for (int p = 1; p <= 12; p++)
                if ((p & q) != 0 && p != q) v ^= c[p-1];
            c[q-1] = v;
        end
        c[12] = ^c[11:0];
        return c;
    endfunction

    function automatic logic [7:0] ref_extract(logic [12:0] c);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) d[i] = c[DPOS[i]-1];
        return d;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: apply a byte and an error pattern, queue the expectation
    task automatic send(logic [7:0] data, logic [12:0] flips, string tag);
        exp_t        e;
        logic [12:0] good;
        int          s;
        int          n;
        good = ref_encode(data);
        n    = $countones(flips);
        s    = 0;
        for (int p = 1; p <= 12; p++) if (flips[p-1]) s ^= p;
        e.tag    = tag;
        e.code   = good;
        e.syn    = 4'(s);
        e.data   = ref_extract(good ^ flips);
        e.single = 1'b0;
        e.pos    = 4'd0;
        e.dbl    = 1'b0;
        if (n == 1) begin
            e.single = 1'b1;
            e.data   = data;
            e.pos    = flips[12] ? 4'd13 : 4'(s);
        end else if (n >= 2) begin
            e.dbl = 1'b1;
        end
        @(negedge clk);
        enc_data_i = data;
        chk_code_i = good ^ flips;
        sb.push_back(e);
    endtask

    // Monitor: compare one queued item per cycle, away from the edge
    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            cur = sb.pop_front();
            cmp(cur.tag, "codeword", int'(enc_code_o),     int'(cur.code));
            cmp(cur.tag, "syndrome", int'(chk_syndrome_o), int'(cur.syn));
            cmp(cur.tag, "data",     int'(chk_data_o),     int'(cur.data));
            cmp(cur.tag, "single",   int'(chk_single_o),   int'(cur.single));
            cmp(cur.tag, "position", int'(chk_err_pos_o),  int'(cur.pos));
            cmp(cur.tag, "double",   int'(chk_double_o),   int'(cur.dbl));
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R9: all-zero inputs, quiet outputs
        send(8'h00, 13'h0000, "R9");

        // R10: directed byte, fixed codeword
        send(8'hC4, 13'h0000, "R10");
        @(posedge clk); #1;
        cmp("R10", "fixed codeword", int'(enc_code_o), 32'h0C21);

        // R1: walking one across data bits places a bit at DPOS[i]
        for (int i = 0; i < 8; i++) begin
            send(8'(1 << i), 13'h0000, "R1");
            @(posedge clk); #1;
            cmp("R1", "placed bit", int'(enc_code_o[DPOS[i]-1]), 1);
        end

        // R2/R3: dense patterns exercise every check group
        send(8'hFF, 13'h0000, "R2");
        send(8'hA5, 13'h0000, "R2");
        send(8'h5A, 13'h0000, "R3");

        // R5: single flip at every covered position
        for (int p = 1; p <= 12; p++) send(8'hA5, 13'(1 << (p - 1)), "R5");

        // R6: only the overall bit flipped
        send(8'h3C, 13'h1000, "R6");
        send(8'hC4, 13'h1000, "R6");

        // R7: double flips
        send(8'h5A, 13'h1001, "R7");   // positions 1 and 13
        send(8'h96, 13'h0014, "R7");   // positions 3 and 5
        send(8'hFF, 13'h0880, "R7");   // positions 8 and 12

        // R8: triple flips aiming the syndrome past position 12
        send(8'h21, 13'h0089, "R8");   // 1,4,8  -> 13
        send(8'h77, 13'h008A, "R8");   // 2,4,8  -> 14
        send(8'h0F, 13'h010A, "R8");   // 2,4,9  -> 15

        // Random mix of 0, 1 and 2 flips
        for (int k = 0; k < 300; k++) begin
            int          n;
            int          a;
            int          b;
            logic [12:0] f;
            n = $urandom_range(0, 2);
            a = $urandom_range(0, 12);
            b = (a + $urandom_range(1, 12)) % 13;
            f = '0;
            if (n >= 1) f[a] = 1'b1;
            if (n == 2) f[b] = 1'b1;
            if (n == 0)      send(8'($urandom), f, "R4");
            else if (n == 1) send(8'($urandom), f, (a == 12) ? "R6" : "R5");
            else             send(8'($urandom), f, "R7");
        end

        while (sb.size() > 0) @(posedge clk);
        @(posedge clk); #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule